// File: doc/BRIEF.md
# Sensor Start-up and Identification Sequencer

This block brings an external motion sensor from power-on to a known, configured state. It sits above a frame transaction engine, which handles the serial shifting and the checksum. It hands that engine one register access at a time and takes back the 16-bit data word, the 2-bit return status and a checksum-error flag. After reset it runs these steps in order:

1. Send the soft-reset command.
2. Wait out the settling interval.
3. Read the identity word.
4. Sort the device into one of two known variants.
5. For the variant that has tilt (angle) outputs, switch those outputs on.

When the sequence ends, the block shows either a ready flag together with the detected variant, or an error flag together with its cause.

Requests leave the block on a valid/ready handshake. Once `req_valid` is high, the block holds `req_write`, `req_addr` and `req_data` steady until a cycle in which `req_ready` is also high. That cycle completes the transfer. The block keeps at most one access outstanding. `rsp_ready` is high only while the block waits for the answer to that access. The engine may keep `rsp_valid` high for as long as it likes, and the answer is taken in the first cycle in which both `rsp_valid` and `rsp_ready` are high. If the device flags an error in its return status, the block inserts one read of the status register, which clears that status. It latches the low nine bits of that read as a fault code and then carries on.

Top module: `startup_seq`

## Requirements
- R1: Reset state. While reset is held and just after it:
  - `ready`, `err` and `fault` are low.
  - The first request offered is a write (`req_write`=1) of data 0x0020 to address 0x0D.
- R2: Settling wait.
  - After the answer to the soft-reset write is accepted, no request is offered for at least SETTLE_CYCLES = CLK_KHZ*SETTLE_MS clock cycles.
  - The next access is then a read (`req_write`=0) of address 0x10.
- R3: An identity word of exactly 0x0051 ends the sequence. `ready` goes high and `variant` is 0. No further request is offered.
- R4: An identity word of exactly 0x00C1 leads to a write of 0x001F to address 0x0C. When that write is answered normally, `ready` goes high and `variant` is 1.
- R5: Any other identity word, all 16 bits compared, ends the sequence with `err` high and `err_kind` = 2'b10 (unknown device).
- R6: Checksum error.
  - An answer with `rsp_crc_err` high ends the sequence at once with `err` high and `err_kind` = 2'b01.
  - There is no retry and no further request.
- R7: Device-error recovery.
  - Trigger: an answer, other than to a status read, with `rsp_status` = 2'b11 and no checksum error.
  - The very next request is a read of status address 0x06.
  - Its answer sets `fault` and loads `rsp_data[8:0]` into `fault_code`.
  - The sequence then continues as if the original answer had been normal, using that answer's data.
- R8: Handshake rules.
  - A pending request keeps its fields stable until `req_ready`.
  - `req_valid` and `rsp_ready` are never high together.
  - Addresses are 5 bits wide (at most 0x1F).
- R9: End states.
  - `ready` and `err` are never high together.
  - Once either is high it stays high, with `variant` or `err_kind` unchanged, until reset.
  - While either is high, `req_valid` and `rsp_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the sequence restarts on release |
| req_valid | output | 1 | Access request offered to the transaction engine |
| req_ready | input | 1 | Engine accepts the request |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 5 | Register address |
| req_data | output | 16 | Write data (0 for reads) |
| rsp_valid | input | 1 | Engine answer available |
| rsp_ready | output | 1 | Block waits for an answer |
| rsp_data | input | 16 | Data word returned by the device |
| rsp_status | input | 2 | Device return status; 2'b11 means device error |
| rsp_crc_err | input | 1 | Checksum of the returned frame was wrong |
| ready | output | 1 | Start-up finished successfully |
| variant | output | 1 | Detected variant (0: 0x0051, 1: 0x00C1); valid while ready |
| err | output | 1 | Start-up aborted |
| err_kind | output | 2 | Abort cause: 01 checksum, 10 unknown identity |
| fault | output | 1 | A device-error status was seen and cleared |
| fault_code | output | 9 | Low nine bits of the clearing status read |

## Verification
Some rules hold on every cycle, and the assertions watch those:
- request fields stay steady while the handshake is pending;
- no request is offered while an answer is awaited;
- the identity read does not come too soon after the last answer;
- a device-error status is followed at once by the status read;
- a checksum error aborts the sequence;
- the two end states hold and stay silent.

Other behaviour is only visible across a whole scenario, so the bench covers it. This includes the exact order of accesses for each identity value, the fault code carried through, and the case where the status read itself has a checksum error. The bench also checks that a recovered answer's data still drives the variant decision.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CODE_W = 9;

  localparam logic [ADDR_W-1:0] A_MODE   = 5'h0D;
  localparam logic [ADDR_W-1:0] A_IDENT  = 5'h10;
  localparam logic [ADDR_W-1:0] A_ANGLE  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h06;

  localparam logic [DATA_W-1:0] D_SOFT_RESET = 16'h0020;
  localparam logic [DATA_W-1:0] D_ANGLE_ON   = 16'h001F;
  localparam logic [DATA_W-1:0] ID_VAR_A     = 16'h0051;
  localparam logic [DATA_W-1:0] ID_VAR_B     = 16'h00C1;

  localparam logic [1:0] RS_DEV_ERR = 2'b11;
  localparam logic [1:0] KIND_COMM  = 2'b01;
  localparam logic [1:0] KIND_IDENT = 2'b10;

  typedef enum logic [1:0] {STP_RESET, STP_IDENT, STP_ANGLE, STP_STATUS} step_e;
  typedef enum logic [2:0] {PH_REQ, PH_RSP, PH_SETTLE, PH_DONE, PH_FAIL} phase_e;

  typedef struct packed {
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } access_t;

  function automatic access_t access_for(step_e s);
    access_t a;
    unique case (s)
      STP_RESET:  a = '{write: 1'b1, addr: A_MODE,   data: D_SOFT_RESET};
      STP_IDENT:  a = '{write: 1'b0, addr: A_IDENT,  data: '0};
      STP_ANGLE:  a = '{write: 1'b1, addr: A_ANGLE,  data: D_ANGLE_ON};
      default:    a = '{write: 1'b0, addr: A_STATUS, data: '0};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CW'(CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign expired = busy_q && (cnt_q == '0);
endmodule

// File: rtl/id_classifier.sv
module id_classifier
  import startup_seq_pkg::*;
(
  input  logic [DATA_W-1:0] ident,
  output logic              known,
  output logic              is_b
);
  logic hit_a, hit_b;
  assign hit_a = (ident == ID_VAR_A);
  assign hit_b = (ident == ID_VAR_B);
  assign known = hit_a | hit_b;
  assign is_b  = hit_b;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned SETTLE_MS = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        rsp_status,
  input  logic              rsp_crc_err,
  output logic              ready,
  output logic              variant,
  output logic              err,
  output logic [1:0]        err_kind,
  output logic              fault,
  output logic [CODE_W-1:0] fault_code
);
  localparam int unsigned SETTLE_CYCLES = (CLK_KHZ * SETTLE_MS < 1) ? 1 : CLK_KHZ * SETTLE_MS;

  step_e             step_q, saved_step_q, post_step;
  phase_e            phase_q;
  logic [DATA_W-1:0] saved_data_q, post_data;
  logic              variant_q, fault_q;
  logic [1:0]        kind_q;
  logic [CODE_W-1:0] code_q;
  access_t           cur;

  logic rsp_fire, need_recover, ok_fire, timer_go, settled, id_known, id_b;

  assign cur          = access_for(step_q);
  assign rsp_fire     = (phase_q == PH_RSP) && rsp_valid;
  assign need_recover = (rsp_status == RS_DEV_ERR) && (step_q != STP_STATUS);
  assign ok_fire      = rsp_fire && !rsp_crc_err && !need_recover;
  assign post_step    = (step_q == STP_STATUS) ? saved_step_q : step_q;
  assign post_data    = (step_q == STP_STATUS) ? saved_data_q : rsp_data;
  assign timer_go     = ok_fire && (post_step == STP_RESET);

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(timer_go), .expired(settled)
  );

  id_classifier u_cls (.ident(post_data), .known(id_known), .is_b(id_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q       <= STP_RESET;
      phase_q      <= PH_REQ;
      saved_step_q <= STP_RESET;
      saved_data_q <= '0;
      variant_q    <= 1'b0;
      kind_q       <= 2'b00;
      fault_q      <= 1'b0;
      code_q       <= '0;
    end else begin
      unique case (phase_q)
        PH_REQ: if (req_ready) phase_q <= PH_RSP;
        PH_RSP: if (rsp_valid) begin
          if (rsp_crc_err) begin
            kind_q  <= KIND_COMM;
            phase_q <= PH_FAIL;
          end else if (need_recover) begin
            saved_step_q <= step_q;
            saved_data_q <= rsp_data;
            step_q       <= STP_STATUS;
            phase_q      <= PH_REQ;
          end else begin
            if (step_q == STP_STATUS) begin
              fault_q <= 1'b1;
              code_q  <= rsp_data[CODE_W-1:0];
            end
            unique case (post_step)
              STP_RESET: phase_q <= PH_SETTLE;
              STP_IDENT: begin
                if (id_b) begin
                  variant_q <= 1'b1;
                  step_q    <= STP_ANGLE;
                  phase_q   <= PH_REQ;
                end else if (id_known) begin
                  variant_q <= 1'b0;
                  phase_q   <= PH_DONE;
                end else begin
                  kind_q  <= KIND_IDENT;
                  phase_q <= PH_FAIL;
                end
              end
              STP_ANGLE: phase_q <= PH_DONE;
              default: begin
                kind_q  <= KIND_COMM;
                phase_q <= PH_FAIL;
              end
            endcase
          end
        end
        PH_SETTLE: if (settled) begin
          step_q  <= STP_IDENT;
          phase_q <= PH_REQ;
        end
        default: ;
      endcase
    end
  end

  assign req_valid  = (phase_q == PH_REQ);
  assign req_write  = cur.write;
  assign req_addr   = cur.addr;
  assign req_data   = cur.data;
  assign rsp_ready  = (phase_q == PH_RSP);
  assign ready      = (phase_q == PH_DONE);
  assign err        = (phase_q == PH_FAIL);
  assign variant    = ready && variant_q;
  assign err_kind   = kind_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned SETTLE_MS = 26
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [4:0]  req_addr,
  input logic [15:0] req_data,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_status,
  input logic        rsp_crc_err,
  input logic        ready,
  input logic        variant,
  input logic        err,
  input logic [1:0]  err_kind
);
  localparam int unsigned SETTLE_CYCLES = (CLK_KHZ * SETTLE_MS < 1) ? 1 : CLK_KHZ * SETTLE_MS;

  logic [31:0] gap_q;
  logic [4:0]  out_addr_q;
  logic        rsp_fire;

  assign rsp_fire = rsp_valid && rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      out_addr_q <= '0;
    end else begin
      if (rsp_fire)               gap_q <= '0;
      else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
      if (req_valid && req_ready) out_addr_q <= req_addr;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_data));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R2
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_addr == 5'h10 |-> gap_q >= SETTLE_CYCLES);

  // R7
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && !rsp_crc_err && rsp_status == 2'b11 && out_addr_q != 5'h06
    |=> req_valid && !req_write && req_addr == 5'h06);

  // R6
  crc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && rsp_crc_err |=> err && err_kind == 2'b01);

  // R9
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && err));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready && $stable(variant));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && $stable(err_kind));

  // R9
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || err) |-> !req_valid && !rsp_ready);
endmodule

bind startup_seq startup_seq_chk #(.CLK_KHZ(CLK_KHZ), .SETTLE_MS(SETTLE_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
  .rsp_crc_err(rsp_crc_err), .ready(ready), .variant(variant), .err(err),
  .err_kind(err_kind)
);

// File: tb/startup_seq_test.sv
module startup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ = 2;
  localparam int MS  = 20;
  localparam int SETTLE = KHZ * MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid, req_ready, req_write, rsp_valid, rsp_ready, rsp_crc_err;
  logic [4:0]  req_addr;
  logic [15:0] req_data, rsp_data;
  logic [1:0]  rsp_status, err_kind;
  logic ready, variant, err, fault;
  logic [8:0] fault_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  startup_seq #(.CLK_KHZ(KHZ), .SETTLE_MS(MS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .rsp_crc_err(rsp_crc_err), .ready(ready),
    .variant(variant), .err(err), .err_kind(err_kind), .fault(fault),
    .fault_code(fault_code)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expectation model
  logic [4:0]  e_addr [8];
  logic        e_wr   [8];
  logic [15:0] e_dat  [8];
  int e_n, g_crc, g_dev;
  bit e_stop, e_ready, e_var, e_fault;
  logic [1:0] e_kind;

  task automatic push(input logic [4:0] a, input logic w, input logic [15:0] d);
    int idx;
    if (e_stop) return;
    idx = e_n;
    e_addr[idx] = a; e_wr[idx] = w; e_dat[idx] = d; e_n++;
    if (g_crc == idx) begin e_stop = 1; e_kind = 2'b01; return; end
    if (g_dev == idx) begin
      e_addr[e_n] = 5'h06; e_wr[e_n] = 1'b0; e_dat[e_n] = 16'h0; e_n++;
      if (g_crc == e_n - 1) begin e_stop = 1; e_kind = 2'b01; end
      else e_fault = 1;
    end
  endtask

  function automatic string tag_for(input logic [4:0] a);
    case (a)
      5'h0D: return "R1";
      5'h10: return "R2";
      5'h0C: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic run_case(input logic [15:0] id, input int crc_at, input int dev_at,
                          input logic [15:0] code);
    int k = 0;
    int last_rsp = 0;
    int guard = 0;
    g_crc = crc_at; g_dev = dev_at;
    e_n = 0; e_stop = 0; e_ready = 0; e_var = 0; e_fault = 0; e_kind = 2'b00;
    push(5'h0D, 1'b1, 16'h0020);
    push(5'h10, 1'b0, 16'h0000);
    if (!e_stop) begin
      if (id == 16'h0051) e_ready = 1;
      else if (id == 16'h00C1) begin
        push(5'h0C, 1'b1, 16'h001F);
        if (!e_stop) begin e_ready = 1; e_var = 1; end
      end else e_kind = 2'b10;
    end

    @(negedge clk);
    rst_n = 1'b0; req_ready = 0; rsp_valid = 0; rsp_data = 0; rsp_status = 0; rsp_crc_err = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!ready && !err && !fault, "R1", "reset outputs", {ready, err, fault}, 0);
    rst_n = 1'b1;

    while (!(ready || err) && guard < 3000) begin
      @(negedge clk); guard++;
      if (req_valid && !(ready || err)) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (k < e_n) begin
          check(req_addr == e_addr[k] && req_write == e_wr[k] && req_data == e_dat[k],
                tag_for(e_addr[k]), "request fields", {req_write, req_addr, req_data},
                {e_wr[k], e_addr[k], e_dat[k]});
        end else check(0, "R9", "extra request", k, e_n);
        if (req_addr == 5'h10)
          check(cyc + 1 - last_rsp >= SETTLE, "R2", "settle gap", cyc + 1 - last_rsp, SETTLE);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat ($urandom_range(0, 4)) @(negedge clk);
        rsp_valid   = 1'b1;
        rsp_data    = (req_addr == 5'h10) ? id : (req_addr == 5'h06) ? code : 16'($urandom);
        rsp_status  = (k == dev_at) ? 2'b11 : 2'($urandom_range(0, 2));
        rsp_crc_err = (k == crc_at);
        while (!rsp_ready) @(negedge clk);
        last_rsp = cyc + 1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_crc_err = 1'b0;
        k++;
      end
    end
    check(guard < 3000, "R9", "watchdog", guard, 3000);
    repeat (6) @(negedge clk);
    check(!req_valid, "R9", "quiet after end", req_valid, 0);
    check(k == e_n, "R6", "request count", k, e_n);
    check(ready == e_ready && !(ready && err), e_var ? "R4" : "R3", "ready", ready, e_ready);
    if (e_ready) check(variant == e_var, e_var ? "R4" : "R3", "variant", variant, e_var);
    check(err == !e_ready, "R5", "err", err, !e_ready);
    if (!e_ready)
      check(err_kind == e_kind, (e_kind == 2'b01) ? "R6" : "R5", "err_kind", err_kind, e_kind);
    check(fault == e_fault, "R7", "fault", fault, e_fault);
    if (e_fault) check(fault_code == code[8:0], "R7", "fault_code", fault_code, code[8:0]);
  endtask

  initial begin
    void'($urandom(32'd20251));
    req_ready = 0; rsp_valid = 0; rsp_data = 0; rsp_status = 0; rsp_crc_err = 0;
    run_case(16'h0051, -1, -1, 16'h0);      // R3
    run_case(16'h00C1, -1, -1, 16'h0);      // R4
    run_case(16'h0000, -1, -1, 16'h0);      // R5
    run_case(16'h0151, -1, -1, 16'h0);      // R5 upper bits matter
    run_case(16'h00C1, 0, -1, 16'h0);       // R6 crc on reset write
    run_case(16'h00C1, 1, -1, 16'h0);       // R6 crc on identity
    run_case(16'h00C1, 2, -1, 16'h0);       // R6 crc on angle write
    run_case(16'h0051, -1, 0, 16'hFE5A);    // R7 error on reset write
    run_case(16'h00C1, -1, 1, 16'h01FF);    // R7 error on identity read
    run_case(16'h00C1, -1, 2, 16'h8003);    // R7 error on angle write
    run_case(16'h0051, 2, 1, 16'h0123);     // R6 crc on clearing read
    for (int i = 0; i < 20; i++) begin
      logic [15:0] rid;
      int sel = $urandom_range(0, 2);
      rid = (sel == 0) ? 16'h0051 : (sel == 1) ? 16'h00C1 : 16'($urandom);
      run_case(rid, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 4) : -1,
               ($urandom_range(0, 2) == 0) ? $urandom_range(0, 2) : -1, 16'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule